// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire PHY management bus of an Ethernet MAC with clause 22 frames. Software places a complete 32-bit management frame in one register. The frame holds the start code, opcode, PHY address, register number, turnaround code and data. The block then clocks the frame onto the bus behind a preamble of ones. It generates the management clock itself, from the system clock, through a programmable divider.

A frame whose opcode field marks a read behaves differently from a write. The block releases the data line for the turnaround and data bits, and samples the 16 bits the PHY returns. It places those bits in the low half of the frame register, with the upper half left as software wrote it. The end of every transfer sets a done flag in an event register. Software clears the flag by writing a one to it. An optional interrupt follows the event flag through a mask. With the mask at zero, software simply polls the flag.

A self-clearing soft reset returns the block to its idle state. It also aborts any transfer that is under way.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After rst_n is released, every register reads 0, and mdc, mdio_oe and irq are low. Register word addresses are: 0 control, 1 event, 2 mask, 3 speed, 4 frame. Any other address reads 0.
- R2: A write to the frame register while the block is idle starts a transfer, and the busy bit (control bit 1) then reads 1. With speed field S, the first mdc rising edge is registered S clock cycles after the write edge. mdc then has a period of 2*S cycles, and a transfer has exactly 64 rising edges.
- R3: On the wire, a transfer sends 32 ones (the preamble) and then frame bits 31 down to 0. While mdio_oe is high, mdio_o changes only together with a falling mdc edge. For a write frame (opcode bits 29:28 not equal to 2'b10), mdio_oe stays high for all 64 bit periods.
- R4: For a read frame (bits 29:28 = 2'b10), mdio_oe is low during the last 18 bit periods, which cover frame bits 17:0. The block samples mdio_i at the rising mdc edges of frame bit positions 15 down to 0 and stores the result MSB first in frame[15:0]. Frame bits 31:16 keep their written value.
- R5: The transfer ends on its 128th mdc transition, which occurs 128*S cycles after the write edge. On that clock edge busy clears and event bit 0 sets. The flag holds until a write to the event register with bit 0 set. Writing 0 leaves the flag unchanged, and writing all ones clears it.
- R6: A write to the frame register while busy is ignored. The register contents and the bits on the wire stay those of the running frame.
- R7: The speed field occupies speed register bits 6:1, and bit 0 reads 0. A speed field of 0 holds mdc low, and a started transfer then stays busy without progressing.
- R8: Writing control bit 0 as 1 starts a soft reset. Bit 0 then reads 1 for 4 cycles and returns to 0 by itself. The soft reset clears the event, mask, speed and frame registers, aborts any transfer, and leaves mdc and mdio_oe low.
- R9: irq equals event bit 0 AND mask bit 0 (mask register bit 0). With the mask at 0, irq stays low while the event flag still sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Masked done event |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Some properties are checked on every cycle. mdc stays low outside a transfer and is frozen when the speed field is zero. The driven data and its enable change only on falling mdc edges. The upper frame bits stay stable when a write arrives during a transfer. Completion always clears busy and sets the event flag, and a soft reset empties the event flag and the transfer state.

Other behaviour only the bench scenarios can show. These are the exact 64-bit wire image against the written frame, and the placement of the read data the PHY returns. They also include the first-edge and end-of-transfer cycle counts for several divider values, the write-one-to-clear rule with the mask and interrupt, and the length of the soft reset pulse.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

   localparam int REG_AW  = 3;
   localparam int FRAME_W = 32;
   localparam int DATA_W  = 16;
   localparam int TA_BITS = 2;

   typedef enum logic [REG_AW-1:0] {
      RA_CTRL  = 3'd0,
      RA_EVENT = 3'd1,
      RA_MASK  = 3'd2,
      RA_SPEED = 3'd3,
      RA_FRAME = 3'd4
   } reg_addr_e;

   localparam int CTRL_SRST_BIT = 0;
   localparam int CTRL_BUSY_BIT = 1;
   localparam int EVT_DONE_BIT  = 0;

   // opcode field value that marks a read frame
   localparam logic [1:0] OP_READ = 2'b10;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise,
   output logic             fall
);

   logic [DIV_W-1:0] cnt_q;
   logic             mdc_q;
   logic             hit;

   assign hit  = run && (div != '0) && (cnt_q >= div - 1'b1);
   assign rise = hit && !mdc_q;
   assign fall = hit && mdc_q;
   assign mdc  = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (div == '0) begin
         cnt_q <= '0;
      end else if (hit) begin
         cnt_q <= '0;
         mdc_q <= !mdc_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R2
   mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc_q);

   // R7
   mdc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && div == '0) |=> $stable(mdc_q));

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
   import mdio_mgmt_pkg::*;
#(
   parameter int PRE_BITS = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               srst,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_word,
   input  logic               rise,
   input  logic               fall,
   input  logic               mdio_i,
   output logic               busy,
   output logic               done,
   output logic [FRAME_W-1:0] frame,
   output logic               mdio_o,
   output logic               mdio_oe
);

   localparam int TOTAL = PRE_BITS + FRAME_W;
   localparam int IDX_W = $clog2(TOTAL);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
   localparam logic [IDX_W-1:0] REL_POS  = IDX_W'(FRAME_W - DATA_W - TA_BITS);
   localparam logic [IDX_W-1:0] SMP_POS  = IDX_W'(FRAME_W - DATA_W);

   logic               busy_q, is_rd_q;
   logic [IDX_W-1:0]   idx_q, fidx;
   logic [FRAME_W-1:0] tx_q, frame_q;
   logic               in_pre, released, sample, last;

   generate
      if (PRE_BITS > 0) begin : g_pre
         assign in_pre = idx_q < IDX_W'(PRE_BITS);
         assign fidx   = idx_q - IDX_W'(PRE_BITS);
      end else begin : g_nopre
         assign in_pre = 1'b0;
         assign fidx   = idx_q;
      end
   endgenerate

   assign last     = idx_q == LAST_IDX;
   assign released = busy_q && is_rd_q && !in_pre && (fidx >= REL_POS);
   assign sample   = rise && released && (fidx >= SMP_POS);
   assign done     = busy_q && fall && last && !srst;
   assign mdio_oe  = busy_q && !released;
   assign mdio_o   = mdio_oe && (in_pre || tx_q[FRAME_W-1]);
   assign busy     = busy_q;
   assign frame    = frame_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         is_rd_q <= 1'b0;
         idx_q   <= '0;
         tx_q    <= '0;
         frame_q <= '0;
      end else if (srst) begin
         busy_q  <= 1'b0;
         is_rd_q <= 1'b0;
         idx_q   <= '0;
         tx_q    <= '0;
         frame_q <= '0;
      end else if (load && !busy_q) begin
         busy_q  <= 1'b1;
         is_rd_q <= load_word[FRAME_W-3 -: 2] == OP_READ;
         idx_q   <= '0;
         tx_q    <= load_word;
         frame_q <= load_word;
      end else if (busy_q) begin
         if (sample)
            frame_q[DATA_W-1:0] <= {frame_q[DATA_W-2:0], mdio_i};
         if (fall) begin
            if (last) busy_q <= 1'b0;
            else      idx_q  <= idx_q + 1'b1;
            if (!in_pre) tx_q <= tx_q << 1;
         end
      end
   end

   // R2
   busy_from_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(load));

   // R3
   data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && !$stable(mdio_o)) |-> $past(fall));

   // R3
   oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q) && !$stable(mdio_oe)) |-> $past(fall));

   // R5
   done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy_q);

   // R6
   busy_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && load && !srst) |=> $stable(frame_q[FRAME_W-1:DATA_W]));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
   import mdio_mgmt_pkg::*;
#(
   parameter int DIV_W      = 6,
   parameter int PRE_BITS   = 32,
   parameter int RST_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);

   localparam int RCNT_W = $clog2(RST_CYCLES + 1);

   initial begin
      assert (DIV_W >= 1 && DIV_W <= 30) else $error("DIV_W out of range");
      assert (PRE_BITS >= 0 && PRE_BITS <= 64) else $error("PRE_BITS out of range");
      assert (RST_CYCLES >= 1) else $error("RST_CYCLES must be positive");
   end

   logic [RCNT_W-1:0] rcnt_q;
   logic              evt_q, mask_q;
   logic [DIV_W-1:0]  spd_q;
   logic              srst, wr_ok, ld, evt_clr;
   logic              busy, done, run, rise, fall;
   logic [FRAME_W-1:0] frame;

   assign srst    = rcnt_q != '0;
   assign wr_ok   = reg_wr && !srst;
   assign ld      = wr_ok && (reg_addr == RA_FRAME);
   assign evt_clr = wr_ok && (reg_addr == RA_EVENT) && reg_wdata[EVT_DONE_BIT];
   assign run     = busy && !srst;
   assign irq     = evt_q && mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rcnt_q <= '0;
         evt_q  <= 1'b0;
         mask_q <= 1'b0;
         spd_q  <= '0;
      end else if (srst) begin
         rcnt_q <= rcnt_q - 1'b1;
         evt_q  <= 1'b0;
         mask_q <= 1'b0;
         spd_q  <= '0;
      end else begin
         evt_q <= (evt_q && !evt_clr) || done;
         if (wr_ok && reg_addr == RA_CTRL && reg_wdata[CTRL_SRST_BIT])
            rcnt_q <= RCNT_W'(RST_CYCLES);
         if (wr_ok && reg_addr == RA_MASK)
            mask_q <= reg_wdata[0];
         if (wr_ok && reg_addr == RA_SPEED)
            spd_q <= reg_wdata[DIV_W:1];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL: begin
            reg_rdata[CTRL_SRST_BIT] = srst;
            reg_rdata[CTRL_BUSY_BIT] = busy;
         end
         RA_EVENT: reg_rdata[EVT_DONE_BIT] = evt_q;
         RA_MASK:  reg_rdata[0] = mask_q;
         RA_SPEED: reg_rdata[DIV_W:1] = spd_q;
         RA_FRAME: reg_rdata = frame;
         default:  reg_rdata = '0;
      endcase
   end

   mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .div  (spd_q),
      .mdc  (mdc),
      .rise (rise),
      .fall (fall)
   );

   mdio_frame_shifter #(.PRE_BITS(PRE_BITS)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .srst     (srst),
      .load     (ld),
      .load_word(reg_wdata),
      .rise     (rise),
      .fall     (fall),
      .mdio_i   (mdio_i),
      .busy     (busy),
      .done     (done),
      .frame    (frame),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe)
   );

   // R5
   done_sets_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> evt_q);

   // R8
   srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (!evt_q && !busy && !mask_q));

endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;

   localparam int CLK_PERIOD = 10;
   localparam int RST_CYCLES = 4;
   localparam logic [2:0] A_CTRL = 3'd0, A_EVT = 3'd1, A_MASK = 3'd2,
                          A_SPD = 3'd3, A_FRAME = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int          n_checks = 0;
   int          n_fail = 0;
   longint      cyc = 0;

   // PHY model state
   logic [15:0] phy_data = '0;
   logic [63:0] wire_bits, oe_bits;
   int          nrise = 0;
   longint      first_rise = 0;
   int          seq_err = 0;
   logic        mdc_p = 1'b0, mdo_p = 1'b0, oe_p = 1'b0;

   always #(CLK_PERIOD/2) clk = !clk;
   always @(posedge clk) cyc <= cyc + 1;

   mdio_mgmt_master u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   function automatic logic phy_bit(int k);
      if (k >= 48 && k < 64) return phy_data[63-k];
      return 1'b1;
   endfunction

   always @(negedge clk) begin
      if (mdc && !mdc_p) begin
         if (nrise == 0) first_rise = cyc;
         if (nrise < 64) begin
            wire_bits[63-nrise] = mdio_o;
            oe_bits[63-nrise]   = mdio_oe;
         end
         nrise = nrise + 1;
         mdio_i = phy_bit(nrise);
      end
      if (oe_p && mdio_oe && (mdio_o != mdo_p) && !(mdc_p && !mdc))
         seq_err = seq_err + 1;
      mdc_p = mdc;
      mdo_p = mdio_o;
      oe_p  = mdio_oe;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [31:0] mk_rd(int pa, int ra);
      return 32'h6002_0000 | (32'(pa) << 23) | (32'(ra) << 18);
   endfunction

   function automatic logic [31:0] mk_wr(int pa, int ra, logic [15:0] v);
      return 32'h5002_0000 | (32'(pa) << 23) | (32'(ra) << 18) | 32'(v);
   endfunction

   task automatic run_frame(input logic [31:0] fr, input int s, input bit rd,
                            input bit intrude, input bit clear_evt);
      logic [31:0] r;
      longint c0;
      int k;
      nrise = 0; seq_err = 0; mdio_i = 1'b1;
      reg_write(A_FRAME, fr);
      c0 = cyc;
      reg_read(A_CTRL, r);
      check("R2 busy after start", 32'(r[1]), 32'd1);
      if (intrude) begin
         repeat (20) @(negedge clk);
         reg_write(A_FRAME, ~fr);
         reg_read(A_FRAME, r);
         check("R6 frame upper kept during busy write", 32'(r[31:16]), 32'(fr[31:16]));
      end
      k = 0;
      reg_read(A_EVT, r);
      while (r[0] == 1'b0 && k < 20000) begin
         @(negedge clk);
         reg_read(A_EVT, r);
         k++;
      end
      check("R5 completion cycle", 32'(cyc - c0), 32'(128 * s));
      check("R2 first rising edge delay", 32'(first_rise - c0), 32'(s));
      check("R2 rising edge count", 32'(nrise), 32'd64);
      reg_read(A_CTRL, r);
      check("R5 busy cleared", 32'(r[1]), 32'd0);
      check("R3 preamble on wire", wire_bits[63:32], 32'hFFFF_FFFF);
      check("R3 changes only on falling edges", 32'(seq_err), 32'd0);
      reg_read(A_FRAME, r);
      if (rd) begin
         check("R3 read header bits on wire", 32'(wire_bits[31:18]), 32'(fr[31:18]));
         check("R4 output enable pattern", oe_bits[31:0], 32'hFFFC_0000);
         check("R4 read data in frame", r, {fr[31:16], phy_data});
      end else begin
         check("R3 write frame on wire", wire_bits[31:0], fr);
         check("R3 output enable held", oe_bits[31:0], 32'hFFFF_FFFF);
         check("R6 frame unchanged", r, fr);
      end
      if (clear_evt) begin
         reg_write(A_EVT, 32'h1);
         reg_read(A_EVT, r);
         check("R5 event cleared by write one", r, 32'd0);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] r;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         reg_read(3'(a), r);
         check("R1 register reset value", r, 32'd0);
      end
      check("R1 mdc/oe/irq low", {29'd0, mdc, mdio_oe, irq}, 32'd0);

      // R7 speed field placement
      reg_write(A_SPD, 32'd5 << 1);
      reg_read(A_SPD, r);
      check("R7 speed readback", r, 32'd10);
      reg_write(A_SPD, 32'h3);
      reg_read(A_SPD, r);
      check("R7 speed bit0 reads zero", r, 32'd2);

      // R2 R3 R4 R5 sweep over speed and frames
      for (int s = 1; s <= 3; s++) begin
         reg_write(A_SPD, 32'(s) << 1);
         for (int j = 0; j < 4; j++) begin
            phy_data = 16'hA5C3 ^ 16'(j * 16'h1111 + s);
            run_frame(mk_rd((j*7+s) % 32, (j*5+3*s) % 32), s, 1'b1, 1'b0, 1'b1);
            run_frame(mk_wr((j*11+s) % 32, (j*3+s) % 32, phy_data ^ 16'h0F0F), s, 1'b0, 1'b0, 1'b1);
         end
      end

      // R6 write while busy, R9 mask and irq, R5 flag hold and all-ones clear
      reg_write(A_SPD, 32'd2 << 1);
      phy_data = 16'h3C96;
      run_frame(mk_rd(9, 17), 2, 1'b1, 1'b1, 1'b0);
      check("R9 irq low with mask zero", 32'(irq), 32'd0);
      reg_write(A_EVT, 32'h0);
      reg_read(A_EVT, r);
      check("R5 write zero keeps flag", r, 32'd1);
      reg_write(A_MASK, 32'h1);
      check("R9 irq with mask set", 32'(irq), 32'd1);
      reg_write(A_EVT, 32'hFFFF_FFFF);
      reg_read(A_EVT, r);
      check("R5 all ones clears flag", r, 32'd0);
      check("R9 irq follows cleared flag", 32'(irq), 32'd0);

      // R7 speed zero stalls
      reg_write(A_SPD, 32'd0);
      reg_write(A_FRAME, mk_wr(3, 4, 16'h1234));
      n = 0;
      repeat (40) begin
         @(negedge clk);
         if (mdc) n++;
      end
      check("R7 mdc held low at speed zero", 32'(n), 32'd0);
      reg_read(A_CTRL, r);
      check("R7 still busy at speed zero", 32'(r[1]), 32'd1);
      reg_read(A_EVT, r);
      check("R7 no completion at speed zero", r, 32'd0);

      // R8 soft reset aborts and clears
      reg_write(A_SPD, 32'd3 << 1);
      repeat (10) @(negedge clk);
      reg_write(A_CTRL, 32'h1);
      n = 0;
      reg_read(A_CTRL, r);
      while (r[0] && n < 100) begin
         n++;
         @(negedge clk);
         reg_read(A_CTRL, r);
      end
      check("R8 reset bit duration", 32'(n), 32'(RST_CYCLES));
      check("R8 busy cleared", 32'(r[1]), 32'd0);
      check("R8 mdc and oe low", {30'd0, mdc, mdio_oe}, 32'd0);
      reg_read(A_MASK, r);
      check("R8 mask cleared", r, 32'd0);
      reg_read(A_SPD, r);
      check("R8 speed cleared", r, 32'd0);
      reg_read(A_FRAME, r);
      check("R8 frame cleared", r, 32'd0);
      reg_read(A_EVT, r);
      check("R8 event cleared", r, 32'd0);

      // operation resumes after soft reset
      reg_write(A_SPD, 32'd1 << 1);
      phy_data = 16'h8001;
      run_frame(mk_rd(31, 31), 1, 1'b1, 1'b0, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule